// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into bytes. While idle it watches the line for a low level. It counts samples on a 16x oversampling clock enable and confirms a start bit at the eighth sample. It then takes each data bit at the middle of its bit period, least significant bit first. An optional parity bit follows, then one or two stop bits. When the frame is complete, the block applies its checks. The byte then moves into an output holding register, which is presented on a valid/ready stream port.

The output port follows one rule for back-pressure. While `out_valid` is high and `out_ready` is low, the held byte stays unchanged. If another frame completes in that time, that frame is dropped and the sticky overrun flag is set. A parity failure or a bad stop bit also sets a sticky flag. In both of those cases the byte is still written to the holding register, but `out_valid` does not rise. While any error flag is set, the receiver starts no new frame. Each flag is cleared by its own strobe.

The block has two level interrupt outputs, both gated by one enable: one for data waiting and one for a pending error. It also has a one-cycle DMA request pulse that fires on every rise of `out_valid`.

Top module: `serial_rx`

## Requirements
- R1: With the line high, the receiver stays idle. A low level seen on an `os_tick` starts a start-bit check. The start is confirmed only if the line is still low on the eighth tick. If the line is high at that tick, the receiver returns to idle and produces no frame.
- R2: After a confirmed start, data bits are sampled every 16 ticks. The first bit received becomes `out_data[0]`.
- R3: When `cfg_par_en`=1, one parity bit follows the data. Define N as the number of 1s in the data bits plus the parity bit. With `cfg_par_odd`=0, N must be even. With `cfg_par_odd`=1, N must be odd. Otherwise `err_parity` is set. When `cfg_par_en`=0, no parity bit is expected.
- R4: The first stop bit must be 1, or else `err_framing` is set. When `cfg_two_stop`=1, the second stop bit is not checked.
- R5: If a frame completes while `out_valid`=1, `err_overrun` is set, the new byte is dropped, and `out_data` and `out_valid` are unchanged.
- R6: On a parity error or a framing error, the byte is still written to `out_data`, the matching flag is set, and `out_valid` stays 0.
- R7: While any error flag is 1, arriving frames are ignored. Reception resumes only after all error flags are clear.
- R8: `irq_rx` = `out_valid` AND `cfg_irq_en`. `irq_err` = (any error flag) AND `cfg_irq_en`.
- R9: `dma_req` is high for exactly one cycle each time `out_valid` rises, regardless of `cfg_irq_en`.
- R10: A cycle with `out_valid`=1 and `out_ready`=1 clears `out_valid`. While `out_ready`=0, the held byte stays valid and unchanged.
- R11: Each error flag is cleared only by its own strobe (`clr_overrun`, `clr_framing`, `clr_parity`). If a set and a clear of the same flag (or of `out_valid`) fall in the same cycle, the set wins.
- R12: After reset, `out_valid`, all error flags, both interrupts and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversampling clock enable |
| rx_line | input | 1 | Serial line (asynchronous, idles high) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_irq_en | input | 1 | Interrupt enable for both interrupts |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Byte held and not yet taken |
| out_ready | input | 1 | Consumer takes the byte |
| clr_overrun | input | 1 | Clear strobe for the overrun flag |
| clr_framing | input | 1 | Clear strobe for the framing flag |
| clr_parity | input | 1 | Clear strobe for the parity flag |
| err_overrun | output | 1 | Sticky overrun flag |
| err_framing | output | 1 | Sticky framing flag |
| err_parity | output | 1 | Sticky parity flag |
| irq_rx | output | 1 | Data-waiting interrupt |
| irq_err | output | 1 | Error interrupt |
| dma_req | output | 1 | One-cycle pulse on each rise of out_valid |

## Verification
Directed frames check each pattern on its own:
- A lone 1 in bit 0 shows the bit order.
- Even parity, odd parity and no parity show that the parity bit is placed and computed correctly.
- A bad parity bit and a low stop bit separate "data written, no valid" from the clean case.
- A low second stop bit shows that only the first stop bit is checked.
- A short low pulse shows glitch rejection.

Sequences check the flow rules:
- Two frames with no read between them show an overrun.
- A frame sent while a flag is set shows that reception is frozen.
- Holding a strobe during frame completion shows that the set wins over the clear.

Random frames with random configuration, random data and injected parity or stop errors are checked against outcomes computed in the bench.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GUARD
  } rx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } rx_cfg_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 1'b1;
        else if (i == 0) pipe[i] <= din;
        else pipe[i] <= pipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  rx_cfg_t           cfg,
  input  logic              hold,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int HALF        = OS / 2;
  localparam int GUARD_TICKS = OS + HALF - 2;
  localparam int CNT_W       = $clog2(GUARD_TICKS + 1);
  localparam int BIT_W       = $clog2(DATA_W + 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bits;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  rx_cfg_t           cfg_q;
  logic              mid;

  assign mid  = (cnt == CNT_W'(OS - 1));
  assign data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bits     <= '0;
      shreg    <= '0;
      pbit     <= 1'b0;
      cfg_q    <= '0;
      done     <= 1'b0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: if (!line && !hold) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: begin
            if (cnt == CNT_W'(HALF - 2)) begin
              cnt  <= '0;
              bits <= '0;
              cfg_q <= cfg;
              state <= line ? ST_IDLE : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (mid) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              bits  <= bits + 1'b1;
              if (bits == BIT_W'(DATA_W - 1))
                state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (mid) begin
              cnt   <= '0;
              pbit  <= line;
              state <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (mid) begin
              cnt      <= '0;
              done     <= 1'b1;
              stop_bad <= !line;
              par_bad  <= cfg_q.par_en && (((^shreg) ^ pbit) != cfg_q.par_odd);
              state    <= cfg_q.two_stop ? ST_GUARD : ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_GUARD: begin
            if (cnt == CNT_W'(GUARD_TICKS - 1)) state <= ST_IDLE;
            else cnt <= cnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              par_bad,
  input  logic              stop_bad,
  input  logic              take,
  input  logic              clr_ovr,
  input  logic              clr_frm,
  input  logic              clr_par,
  input  logic              irq_en,
  output logic [DATA_W-1:0] hold_data,
  output logic              full,
  output logic              ovr,
  output logic              frm,
  output logic              par,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              dma_req
);
  logic ovr_set, copy, full_set;

  assign ovr_set  = done && full;
  assign copy     = done && !full;
  assign full_set = copy && !par_bad && !stop_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      full      <= 1'b0;
      ovr       <= 1'b0;
      frm       <= 1'b0;
      par       <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      if (copy) hold_data <= frame_data;
      full    <= full_set ? 1'b1 : (take ? 1'b0 : full);
      ovr     <= ovr_set ? 1'b1 : (clr_ovr ? 1'b0 : ovr);
      frm     <= (done && stop_bad) ? 1'b1 : (clr_frm ? 1'b0 : frm);
      par     <= (done && par_bad) ? 1'b1 : (clr_par ? 1'b0 : par);
      dma_req <= full_set;
    end
  end

  assign irq_rx  = full && irq_en;
  assign irq_err = (ovr || frm || par) && irq_en;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_irq_en,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              clr_overrun,
  input  logic              clr_framing,
  input  logic              clr_parity,
  output logic              err_overrun,
  output logic              err_framing,
  output logic              err_parity,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              dma_req
);
  logic              line_s;
  logic              done, par_bad, stop_bad;
  logic [DATA_W-1:0] frame_data;
  rx_cfg_t           cfg;

  assign cfg = '{par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  serial_rx_frame #(.DATA_W(DATA_W), .OS(OS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .cfg(cfg),
    .hold(err_overrun || err_framing || err_parity),
    .done(done), .data(frame_data), .par_bad(par_bad), .stop_bad(stop_bad)
  );

  serial_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .done(done), .frame_data(frame_data),
    .par_bad(par_bad), .stop_bad(stop_bad), .take(out_valid && out_ready),
    .clr_ovr(clr_overrun), .clr_frm(clr_framing), .clr_par(clr_parity),
    .irq_en(cfg_irq_en), .hold_data(out_data), .full(out_valid),
    .ovr(err_overrun), .frm(err_framing), .par(err_parity),
    .irq_rx(irq_rx), .irq_err(irq_err), .dma_req(dma_req)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              err_overrun,
  input logic              err_framing,
  input logic              err_parity,
  input logic              cfg_irq_en,
  input logic              irq_rx,
  input logic              irq_err,
  input logic              dma_req
);
  logic err_any;
  assign err_any = err_overrun || err_framing || err_parity;

  a_r5_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $stable(out_data) && $past(out_valid));

  a_r6_no_valid_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_framing) || $rose(err_parity)) |-> !$rose(out_valid));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_any) |-> !$rose(out_valid));

  a_r8_irq_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx == (out_valid && cfg_irq_en)) && (irq_err == (err_any && cfg_irq_en)));

  a_r9_dma_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $rose(out_valid));

  a_r9_rise_gives_dma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> dma_req);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
endmodule

bind serial_rx serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .err_overrun(err_overrun), .err_framing(err_framing),
  .err_parity(err_parity), .cfg_irq_en(cfg_irq_en), .irq_rx(irq_rx),
  .irq_err(irq_err), .dma_req(dma_req)
);

// File: tb/serial_rx_bench.sv
`timescale 1ns/1ps
module serial_rx_bench;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_line = 1'b1;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_irq_en = 1'b0;
  logic out_ready = 1'b0, clr_overrun = 1'b0, clr_framing = 1'b0, clr_parity = 1'b0;
  logic [7:0] out_data;
  logic out_valid, err_overrun, err_framing, err_parity, irq_rx, irq_err, dma_req;

  int checks = 0, errors = 0, dma_cnt = 0, par_hi = 0, val_hi = 0, tdiv = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TDIV-1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TDIV-1);
    if (dma_req) dma_cnt <= dma_cnt + 1;
    if (err_parity) par_hi <= par_hi + 1;
    if (out_valid) val_hi <= val_hi + 1;
  end

  serial_rx u_serial_rx (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic par_bit(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic send_bit(logic b);
    rx_line = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, bit bad_par, bit bad_stop, logic stop2);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (cfg_par_en) send_bit(par_bit(d, cfg_par_odd) ^ bad_par);
    send_bit(!bad_stop);
    if (cfg_two_stop) send_bit(stop2);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    out_ready = 1; clr_overrun = 1; clr_framing = 1; clr_parity = 1;
    @(negedge clk);
    out_ready = 0; clr_overrun = 0; clr_framing = 0; clr_parity = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid", out_valid, 0);
    chk("R12 flags", {err_overrun, err_framing, err_parity}, 0);
    chk("R12 irq/dma", {irq_rx, irq_err, dma_req}, 0);

    // R2 bit order, no parity
    d0 = dma_cnt;
    send_frame(8'h01, 0, 0, 1);
    chk("R2 lsb first", out_data, 8'h01);
    chk("R9 dma pulse", dma_cnt - d0, 1);
    chk("R8 irq_rx off", irq_rx, 0);
    cfg_irq_en = 1;
    @(negedge clk);
    chk("R8 irq_rx on", irq_rx, 1);
    chk("R10 hold valid", out_valid, 1);
    pulse_clear();
    chk("R10 take clears", out_valid, 0);

    // R3 even and odd parity
    cfg_par_en = 1; cfg_par_odd = 0;
    send_frame(8'hA7, 0, 0, 1);
    chk("R3 even data", out_data, 8'hA7);
    chk("R3 even ok", {out_valid, err_parity}, 2'b10);
    pulse_clear();
    cfg_par_odd = 1;
    send_frame(8'h3C, 0, 0, 1);
    chk("R3 odd ok", {out_valid, err_parity}, 2'b10);
    pulse_clear();

    // R6 parity error delivers data, no valid
    d0 = dma_cnt;
    send_frame(8'h5E, 1, 0, 1);
    chk("R6 parity flag", {out_valid, err_parity, err_framing}, 3'b010);
    chk("R6 data copied", out_data, 8'h5E);
    chk("R8 irq_err", irq_err, 1);
    chk("R9 no dma on err", dma_cnt - d0, 0);

    // R7 frozen while flag set
    send_frame(8'h11, 0, 0, 1);
    chk("R7 frozen data", out_data, 8'h5E);
    chk("R7 frozen valid", out_valid, 0);
    @(negedge clk); clr_parity = 1; @(negedge clk); clr_parity = 0;
    chk("R11 parity cleared", err_parity, 0);
    send_frame(8'h22, 0, 0, 1);
    chk("R7 resumed", {out_valid, 8'(out_data)}, {1'b1, 8'h22});
    pulse_clear();

    // R4 framing error; two stop with bad second stop ignored
    cfg_par_en = 0;
    send_frame(8'h99, 0, 1, 1);
    chk("R4 framing flag", {out_valid, err_framing}, 2'b01);
    chk("R6 framing data", out_data, 8'h99);
    @(negedge clk); clr_overrun = 1; clr_parity = 1; @(negedge clk); clr_overrun = 0; clr_parity = 0;
    chk("R11 own strobe only", err_framing, 1);
    pulse_clear();
    cfg_two_stop = 1;
    send_frame(8'h6B, 0, 0, 0);
    chk("R4 second stop unchecked", {out_valid, err_framing, 8'(out_data)}, {2'b10, 8'h6B});
    pulse_clear();
    cfg_two_stop = 0;

    // R1 glitch rejected
    d0 = dma_cnt;
    rx_line = 0; repeat (5 * TDIV) @(negedge clk);
    rx_line = 1; repeat (3 * BITC) @(negedge clk);
    chk("R1 glitch", {out_valid, err_framing, err_parity}, 0);
    chk("R1 glitch dma", dma_cnt - d0, 0);
    send_frame(8'hC4, 0, 0, 1);
    chk("R1 after glitch", out_data, 8'hC4);

    // R5 overrun: second frame without reading
    send_frame(8'h0F, 0, 0, 1);
    chk("R5 overrun flag", err_overrun, 1);
    chk("R5 data kept", {out_valid, 8'(out_data)}, {1'b1, 8'hC4});
    pulse_clear();

    // R11 set wins over held clear; R10 set wins over held ready
    cfg_par_en = 1; cfg_par_odd = 0;
    par_hi = 0; clr_parity = 1;
    send_frame(8'h81, 1, 0, 1);
    clr_parity = 0;
    chk("R11 set wins", par_hi, 1);
    chk("R11 cleared after", err_parity, 0);
    val_hi = 0; d0 = dma_cnt; out_ready = 1;
    send_frame(8'h47, 0, 0, 1);
    out_ready = 0;
    chk("R10 set wins", val_hi, 1);
    chk("R10 dma", dma_cnt - d0, 1);
    chk("R10 data", out_data, 8'h47);

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      bit bp, bs;
      d = 8'($urandom);
      cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom); cfg_two_stop = 1'($urandom);
      bp = ($urandom % 4) == 0; bs = ($urandom % 8) == 0;
      d0 = dma_cnt;
      send_frame(d, bp, bs, 1'($urandom));
      chk("R2 random data", out_data, d);
      chk("R3 random parity", err_parity, cfg_par_en && bp);
      chk("R4 random framing", err_framing, bs);
      chk("R6 random valid", out_valid, !(cfg_par_en && bp) && !bs);
      chk("R9 random dma", dma_cnt - d0, !(cfg_par_en && bp) && !bs);
      pulse_clear();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd12345));
endmodule